// File: doc/BRIEF.md
# Branch-Anticipating Pipeline Depth Controller

This block decides, cycle by cycle, which registers of a five-register processor pipeline are made transparent. Its aim is to stop the front end from fetching down a path that a branch is about to throw away. The early decode stage hands it each 32-bit instruction word with a valid strobe. It also reports whether a branch was taken, whether the first word from a branch target has arrived, and whether a multi-cycle operation is in progress.

An instruction that updates the condition flags signals that a conditional branch is probably close. On seeing one, the controller makes every pipeline register transparent, so the pipeline runs at depth 1. No further word is then fetched ahead of a branch whose target is unknown. Once the branch target's first word has been fetched, all registers are clocked again and the pipeline returns to full depth.

A mode input selects the behaviour in single-step. In the basic behaviour, single-step is held until the branch target shows up. In the early-return behaviour, a conditional instruction that is not a branch ends single-step at once, because the flags were evidently consumed by something other than a branch.

Top module: `pipe_depth_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every collapse bit is 0 (full depth).
- R2: A valid instruction with bits [27:26] = 00 and bit 20 = 1 (flag-setting) makes every collapse bit 1 from the next cycle on. The exception is the bit covered by R7.
- R3: In single-step, a valid cycle with target_fetched high and no flag-setting word clears every collapse bit from the next cycle.
- R4: With early_mode = 0, a valid conditional non-branch word does not leave single-step. Conditional means bits [31:28] are not 1110. Branch means bits [27:25] = 101.
- R5: With early_mode = 1, a valid conditional non-branch word seen after a flag-setting word, and before any taken branch, returns to full depth in the next cycle.
- R6: Once branch_taken has been seen in single-step, a conditional non-branch word does not leave single-step, even with early_mode = 1.
- R7: While multicycle is high, collapse bit 3 (the decode-to-execute register) is 0 in the same cycle, in every mode. The other bits are unaffected.
- R8: When instr_valid is low, the depth state does not change, whatever the other inputs are.
- R9: A flag-setting word arriving in the same cycle as target_fetched leaves the block in single-step.
- R10: A taken branch alone does not restore full depth. The collapse bits stay at 1 until target_fetched arrives.
- R11: A conditional flag-setting word in early_mode enters single-step. Flag detection takes priority over the early-return rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_mode | input | 1 | 1 selects early return on conditional non-branch words |
| instr_valid | input | 1 | Decode stage presents a valid word this cycle |
| instr_word | input | 32 | Instruction word from the early decode stage |
| branch_taken | input | 1 | The presented word is a branch that was taken |
| target_fetched | input | 1 | The first word from a branch target has been fetched |
| multicycle | input | 1 | A multi-cycle operation occupies the execute stage |
| collapse | output | 5 | One transparency control per pipeline register; bit 3 is decode-to-execute |

## Verification
The hardest state to reach is the waiting state that follows a taken branch in early mode. There, a conditional non-branch word must not end single-step, yet the same word one step earlier would have ended it. The ports cannot tell this waiting state apart from the armed state. The stimulus therefore drives the exact order flag-setting word, taken branch, conditional word, and then confirms through the collapse outputs that depth 1 is held. A long pseudo-random mix of words and flags, compared every cycle against a behavioural model, then covers the coincident cases, including flag-setting with target-fetched and multicycle during single-step.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [1:0] {
      ST_FULL  = 2'd0,
      ST_ARMED = 2'd1,
      ST_AWAIT = 2'd2
   } depth_state_t;

   typedef struct packed {
      logic sets_flags;
      logic is_cond;
      logic is_branch;
   } instr_class_t;

   localparam logic [3:0] COND_ALWAYS = 4'b1110;
   localparam logic [2:0] BRANCH_OPC  = 3'b101;
   localparam logic [1:0] DP_CLASS    = 2'b00;

endpackage

// File: rtl/pdc_classify.sv
module pdc_classify
   import pdc_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr_word,
   output instr_class_t       cls
);
   localparam int COND_HI = INSTR_W - 1;
   localparam int COND_LO = INSTR_W - 4;
   localparam int SFLAG   = 20;

   always_comb begin
      cls.is_cond    = (instr_word[COND_HI:COND_LO] != COND_ALWAYS);
      cls.is_branch  = (instr_word[27:25] == BRANCH_OPC);
      cls.sets_flags = (instr_word[27:26] == DP_CLASS) && instr_word[SFLAG];
   end
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
   import pdc_pkg::*;
#(
   parameter bit EARLY_EXIT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         early_mode,
   input  logic         instr_valid,
   input  instr_class_t cls,
   input  logic         branch_taken,
   input  logic         target_fetched,
   output logic         single_step
);
   depth_state_t state_q, state_d;
   logic         early_hit;

   generate
      if (EARLY_EXIT_EN) begin : g_early
         assign early_hit = early_mode & cls.is_cond & ~cls.is_branch;
      end else begin : g_no_early
         logic unused_mode;
         assign unused_mode = early_mode;
         assign early_hit   = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (instr_valid) begin
         if (cls.sets_flags)
            state_d = ST_ARMED;
         else if (target_fetched)
            state_d = ST_FULL;
         else if (branch_taken && state_q != ST_FULL)
            state_d = ST_AWAIT;
         else if (early_hit && state_q == ST_ARMED)
            state_d = ST_FULL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_FULL;
      else        state_q <= state_d;
   end

   assign single_step = (state_q != ST_FULL);
endmodule

// File: rtl/pdc_collapse.sv
module pdc_collapse #(
   parameter int NUM_STAGES = 5,
   parameter int DE_INDEX   = 3
) (
   input  logic                  single_step,
   input  logic                  multicycle,
   output logic [NUM_STAGES-1:0] collapse
);
   generate
      for (genvar g = 0; g < NUM_STAGES; g++) begin : g_bit
         if (g == DE_INDEX) begin : g_de
            assign collapse[g] = single_step & ~multicycle;
         end else begin : g_plain
            assign collapse[g] = single_step;
         end
      end
   endgenerate
endmodule

// File: rtl/pipe_depth_ctrl.sv
module pipe_depth_ctrl
   import pdc_pkg::*;
#(
   parameter int NUM_STAGES    = 5,
   parameter int DE_INDEX      = 3,
   parameter int INSTR_W       = 32,
   parameter bit EARLY_EXIT_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  early_mode,
   input  logic                  instr_valid,
   input  logic [INSTR_W-1:0]    instr_word,
   input  logic                  branch_taken,
   input  logic                  target_fetched,
   input  logic                  multicycle,
   output logic [NUM_STAGES-1:0] collapse
);
   generate
      if (INSTR_W != 32) begin : g_bad_w
         $error("pipe_depth_ctrl: INSTR_W must be 32");
      end
      if (NUM_STAGES < 2 || NUM_STAGES > 16) begin : g_bad_n
         $error("pipe_depth_ctrl: NUM_STAGES out of range");
      end
      if (DE_INDEX < 1 || DE_INDEX >= NUM_STAGES) begin : g_bad_de
         $error("pipe_depth_ctrl: DE_INDEX out of range");
      end
   endgenerate

   instr_class_t cls;
   logic         single_step;

   pdc_classify #(.INSTR_W(INSTR_W)) u_classify (
      .instr_word (instr_word),
      .cls        (cls)
   );

   pdc_fsm #(.EARLY_EXIT_EN(EARLY_EXIT_EN)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .early_mode     (early_mode),
      .instr_valid    (instr_valid),
      .cls            (cls),
      .branch_taken   (branch_taken),
      .target_fetched (target_fetched),
      .single_step    (single_step)
   );

   pdc_collapse #(.NUM_STAGES(NUM_STAGES), .DE_INDEX(DE_INDEX)) u_collapse (
      .single_step (single_step),
      .multicycle  (multicycle),
      .collapse    (collapse)
   );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
   parameter int NUM_STAGES = 5,
   parameter int DE_INDEX   = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  early_mode,
   input logic                  instr_valid,
   input logic [31:0]           instr_word,
   input logic                  branch_taken,
   input logic                  target_fetched,
   input logic                  multicycle,
   input logic [NUM_STAGES-1:0] collapse
);
   logic fs, cnb;
   assign fs  = (instr_word[27:26] == 2'b00) && instr_word[20];
   assign cnb = (instr_word[31:28] != 4'hE) && (instr_word[27:25] != 3'b101);

   always_comb begin
      if (!rst_n) assert_reset_full_R1: assert (collapse == '0);
   end

   assert_flag_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && fs |=> collapse[0]);

   assert_target_restores_R3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && target_fetched && !fs |=> !collapse[0]);

   assert_basic_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !early_mode && instr_valid && cnb && !fs && !target_fetched && collapse[0]
      |=> collapse[0]);

   assert_de_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      multicycle |-> !collapse[DE_INDEX]);

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(collapse[0]));

   assert_flag_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && fs && target_fetched |=> collapse[0]);

   assert_taken_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && branch_taken && !target_fetched && collapse[0] |=> collapse[0]);
endmodule

bind pipe_depth_ctrl pdc_checker #(.NUM_STAGES(NUM_STAGES), .DE_INDEX(DE_INDEX)) u_pdc_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .early_mode     (early_mode),
   .instr_valid    (instr_valid),
   .instr_word     (instr_word),
   .branch_taken   (branch_taken),
   .target_fetched (target_fetched),
   .multicycle     (multicycle),
   .collapse       (collapse)
);

// File: tb/test_pipe_depth_ctrl.sv
`timescale 1ns/1ps
module test_pipe_depth_ctrl;
   localparam int N = 5;
   localparam int DE = 3;

   localparam logic [31:0] W_PLAIN   = 32'hE000_0000;
   localparam logic [31:0] W_FLAG    = 32'hE010_0000;
   localparam logic [31:0] W_CONDDP  = 32'h0000_0000;
   localparam logic [31:0] W_BRANCH  = 32'h0A00_0000;
   localparam logic [31:0] W_CONDFLG = 32'h1010_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         early_mode = 1'b0;
   logic         instr_valid = 1'b0;
   logic [31:0]  instr_word = '0;
   logic         branch_taken = 1'b0;
   logic         target_fetched = 1'b0;
   logic         multicycle = 1'b0;
   logic [N-1:0] collapse;

   int checks = 0;
   int failures = 0;
   int mstate = 0; // 0 full, 1 armed, 2 waiting for target
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pipe_depth_ctrl i_pipe_depth_ctrl (
      .clk(clk), .rst_n(rst_n), .early_mode(early_mode),
      .instr_valid(instr_valid), .instr_word(instr_word),
      .branch_taken(branch_taken), .target_fetched(target_fetched),
      .multicycle(multicycle), .collapse(collapse)
   );

   function automatic logic [N-1:0] expect_vec(int st, logic mc);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (st != 0) && !(i == DE && mc);
      return v;
   endfunction

   task automatic check_now(string tag);
      logic [N-1:0] exp;
      exp = expect_vec(mstate, multicycle);
      checks++;
      if (collapse !== exp) begin
         failures++;
         $display("FAIL %s: collapse=%b expected=%b at %0t", tag, collapse, exp, $time);
      end
   endtask

   task automatic model_update();
      logic fs, cnb;
      fs  = (instr_word[27:26] == 2'b00) && instr_word[20];
      cnb = (instr_word[31:28] != 4'hE) && (instr_word[27:25] != 3'b101);
      if (instr_valid) begin
         if (fs) mstate = 1;
         else if (target_fetched) mstate = 0;
         else if (branch_taken && mstate != 0) mstate = 2;
         else if (early_mode && cnb && mstate == 1) mstate = 0;
      end
   endtask

   // drive at the falling edge, check mid-phase, model follows the rising edge
   task automatic step(logic v, logic [31:0] w, logic bt, logic tf, logic mc,
                       logic em, string tag);
      @(negedge clk);
      instr_valid = v; instr_word = w; branch_taken = bt;
      target_fetched = tf; multicycle = mc; early_mode = em;
      #1 check_now(tag);
      @(posedge clk);
      model_update();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      logic [31:0] pick;
      repeat (3) @(negedge clk);
      #1 check_now("R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      #1 check_now("R1 after release");

      step(1, W_PLAIN,  0, 0, 0, 0, "R1 plain word stays full");
      step(1, W_FLAG,   0, 0, 0, 0, "R2 flag word seen");
      step(1, W_PLAIN,  0, 0, 0, 0, "R2 depth 1 reached");
      step(1, W_PLAIN,  0, 0, 1, 0, "R7 multicycle in single-step");
      step(1, W_CONDDP, 0, 0, 0, 0, "R4 cond word presented");
      step(0, W_PLAIN,  0, 1, 0, 1, "R4 basic mode still collapsed");
      step(0, W_CONDDP, 1, 1, 0, 1, "R8 idle cycle ignored");
      step(1, W_PLAIN,  0, 1, 0, 0, "R8 state held while idle");
      step(1, W_PLAIN,  0, 0, 0, 0, "R3 full depth after target");
      step(1, W_FLAG,   0, 1, 0, 0, "R9 flag with target");
      step(1, W_PLAIN,  0, 0, 0, 0, "R9 flag wins");
      step(1, W_BRANCH, 1, 0, 0, 1, "R10 taken branch presented");
      step(1, W_CONDDP, 0, 0, 0, 1, "R10 still collapsed after taken");
      step(1, W_PLAIN,  0, 0, 0, 1, "R6 no early return while waiting");
      step(1, W_PLAIN,  0, 1, 0, 1, "R6 still collapsed");
      step(1, W_FLAG,   0, 0, 0, 1, "R3 restored before rearm");
      step(1, W_CONDDP, 0, 0, 0, 1, "R5 armed in early mode");
      step(1, W_CONDFLG,0, 0, 0, 1, "R5 early return done");
      step(1, W_CONDDP, 0, 0, 1, 1, "R11 conditional flag word arms");
      step(1, W_PLAIN,  0, 0, 1, 0, "R7 multicycle at full depth");

      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[2:0])
            3'd0, 3'd1: pick = W_PLAIN;
            3'd2:       pick = W_FLAG;
            3'd3, 3'd4: pick = W_CONDDP;
            3'd5:       pick = W_BRANCH;
            default:    pick = W_CONDFLG;
         endcase
         step(lfsr[3] | lfsr[4], pick, lfsr[5] & lfsr[6], lfsr[7] & lfsr[8] & lfsr[9],
              lfsr[10] & lfsr[11], lfsr[12], "R2 R3 R5 mixed sequence");
      end
      step(0, W_PLAIN, 0, 0, 0, 0, "R8 final compare");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule